// File: doc/BRIEF.md
# CAN Frame Field Parser

This block sits behind a CAN bit sampler and destuffer. Each bit it accepts is already free of stuff bits and carries its position within the frame, counted from the start-of-frame bit at index 0. The parser takes a standard (11-bit identifier) or extended (29-bit identifier) data or remote frame apart into its fields. It tracks the bus layout as it goes: the identifier-extension bit picks one of two field maps, and the data length code fixes where the data field ends. The CRC, acknowledge and end-of-frame fields are placed relative to that end.

Once the last end-of-frame bit has been seen, the parser raises a single-cycle completion pulse. It then goes idle and holds every decoded field steady for the consumer until the next start-of-frame bit arrives. Two warning flags report a recessive start bit and any dominant level where the frame format calls for a recessive one. CRC checking, error and overload frames, and acknowledge driving are handled elsewhere.

Top module: `canFrameParser`

## Requirements
- R1: An accepted bit with index 0 starts a new frame, in any state. In the cycle after it, every decoded output and flag is cleared, and `sofWarn` equals the level of that bit (1 = recessive = warning).
- R2: Bits 1..11 form the base identifier, most significant bit first. For a standard frame `frameId[10:0]` holds the base identifier and `frameId[28:11]` is zero.
- R3: Bit 13 selects the frame format: 0 gives a standard frame (`isExt`=0), 1 gives an extended frame (`isExt`=1). In an extended frame, bits 14..31 form an 18-bit extension, and `frameId` = (base identifier << 18) | extension.
- R4: The remote flag comes from bit 12 in a standard frame and from bit 32 in an extended frame. A 1 marks a remote frame, which has no data bytes, so its CRC field starts directly after the DLC. In an extended frame, bit 12 does not affect `isRemote`.
- R5: The 4-bit DLC, sent MSB first, occupies bits 15..18 (standard) or bits 35..38 (extended) and appears on `dlc` as received. The data bytes follow it, each sent MSB first. Byte k appears on `dataOut[8k+7:8k]`, and bytes that were not received read as zero.
- R6: A DLC above 8 carries exactly 8 data bytes.
- R7: The 15 bits after the last data bit are the CRC field, MSB first, shown on `crcOut`.
- R8: The bit 17 positions after the last data bit is the ACK slot. `ackOk` is 1 when it is dominant (0) and 0 when it is recessive.
- R9: A dominant level on the CRC delimiter (last data bit + 16), the ACK delimiter (+18) or any of the 7 end-of-frame bits (+19..+25) sets `formErr`. Parsing continues to the end of the frame.
- R10: `frameDone` is high for exactly one cycle, in the cycle after the last end-of-frame bit (last data bit + 25) is accepted. The parser then goes idle.
- R11: After the completion pulse, all decoded outputs stay unchanged until the next bit with index 0. Bits with any other index that arrive while idle are ignored.
- R12: The reserved bits (bit 14 in a standard frame, bits 33 and 34 in an extended frame) are accepted at either level and change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitValid | input | 1 | A destuffed bit is presented this cycle |
| bitVal | input | 1 | Bit level, 0 = dominant, 1 = recessive |
| bitIdx | input | IDX_W (7) | Position of the bit within the frame, 0 = start of frame |
| frameId | output | 29 | Decoded identifier |
| isExt | output | 1 | Extended-format frame |
| isRemote | output | 1 | Remote frame |
| dlc | output | 4 | Data length code as received |
| dataOut | output | 64 | Data bytes, byte k at [8k+7:8k] |
| crcOut | output | 15 | Received CRC field |
| ackOk | output | 1 | ACK slot was dominant |
| sofWarn | output | 1 | Start bit was recessive |
| formErr | output | 1 | Dominant level on a delimiter or end-of-frame bit |
| frameDone | output | 1 | One-cycle frame completion pulse |

## Verification
The hardest cases to reach are the ones where the tail of the frame moves. The CRC, ACK and end-of-frame positions depend on the frame format, the remote flag and a clamped DLC all at once, so a wrong data-end position only shows up for particular combinations. The bench builds complete frames in a bench function. It covers directed remote frames, frames with DLC 0 and DLC above 8, and a fault injected on each delimiter kind and on an end-of-frame bit. It then adds random frames of both formats, with random gaps between bits and random reserved-bit and SRR levels.

// File: rtl/canParsePkg.sv
package canParsePkg;
  localparam int BASE_ID_W = 11;
  localparam int EXT_ID_W  = 18;
  localparam int ID_W      = BASE_ID_W + EXT_ID_W;
  localparam int DLC_W     = 4;
  localparam int CRC_W     = 15;
  localparam int EOF_LEN   = 7;
  localparam int MAX_BYTES = 8;
  localparam int DATA_W    = MAX_BYTES * 8;
  localparam int OFF_W     = $clog2(DATA_W);
  localparam int POS_W     = 8;

  // Bit positions the field maps depend on
  localparam logic [POS_W-1:0] POS_BASE_LO  = 8'd1;
  localparam logic [POS_W-1:0] POS_BASE_HI  = POS_BASE_LO + BASE_ID_W - 1;
  localparam logic [POS_W-1:0] POS_BIT12    = POS_BASE_HI + 1;
  localparam logic [POS_W-1:0] POS_IDE      = POS_BIT12 + 1;
  localparam logic [POS_W-1:0] STD_DLC_END  = POS_IDE + 1 + DLC_W;
  localparam logic [POS_W-1:0] POS_EXT_LO   = POS_IDE + 1;
  localparam logic [POS_W-1:0] POS_EXT_HI   = POS_EXT_LO + EXT_ID_W - 1;
  localparam logic [POS_W-1:0] POS_RTR_EXT  = POS_EXT_HI + 1;
  localparam logic [POS_W-1:0] EXT_DLC_END  = POS_RTR_EXT + 2 + DLC_W;
  // Tail offsets relative to the last data bit
  localparam logic [POS_W-1:0] OFS_CRC_HI   = CRC_W;
  localparam logic [POS_W-1:0] OFS_CRC_DEL  = OFS_CRC_HI + 1;
  localparam logic [POS_W-1:0] OFS_ACK      = OFS_CRC_DEL + 1;
  localparam logic [POS_W-1:0] OFS_ACK_DEL  = OFS_ACK + 1;
  localparam logic [POS_W-1:0] OFS_EOF_LO   = OFS_ACK_DEL + 1;
  localparam logic [POS_W-1:0] OFS_EOF_HI   = OFS_EOF_LO + EOF_LEN - 1;

  typedef enum logic {ST_IDLE, ST_FIELDS} parseState_t;

  typedef struct packed {
    logic             sof;
    logic             baseBit;
    logic             bit12;
    logic             ideBit;
    logic             extBit;
    logic             rtrExtBit;
    logic             dlcBit;
    logic             dataBit;
    logic [OFF_W-1:0] dataOff;
    logic             crcBit;
    logic             ackBit;
    logic             mustRec;
    logic             done;
  } fieldStrb_t;
endpackage

// File: rtl/canFieldCtrl.sv
module canFieldCtrl
  import canParsePkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             isExt,
  input  logic             isRemote,
  input  logic [DLC_W-1:0] dlcRaw,
  output fieldStrb_t       strb
);
  parseState_t state;
  logic             sofHit;
  logic             act;
  logic [POS_W-1:0] idx;
  logic [POS_W-1:0] dlcEnd;
  logic [POS_W-1:0] dlcLo;
  logic [DLC_W-1:0] nBytes;
  logic [POS_W-1:0] lastData;
  logic [POS_W-1:0] dataOffWide;

  always_comb begin
    idx      = POS_W'(bitIdx);
    sofHit   = bitValid && (bitIdx == '0);
    act      = bitValid && (state == ST_FIELDS) && (bitIdx != '0);
    dlcEnd   = isExt ? EXT_DLC_END : STD_DLC_END;
    dlcLo    = dlcEnd - POS_W'(DLC_W - 1);
    if (isRemote)
      nBytes = '0;
    else if (dlcRaw > DLC_W'(MAX_BYTES))
      nBytes = DLC_W'(MAX_BYTES);
    else
      nBytes = dlcRaw;
    lastData    = dlcEnd + {nBytes, 3'b000};
    dataOffWide = idx - dlcEnd - 8'd1;
  end

  always_comb begin
    strb           = '0;
    strb.sof       = sofHit;
    strb.baseBit   = act && (idx >= POS_BASE_LO) && (idx <= POS_BASE_HI);
    strb.bit12     = act && (idx == POS_BIT12);
    strb.ideBit    = act && (idx == POS_IDE);
    strb.extBit    = act && isExt && (idx >= POS_EXT_LO) && (idx <= POS_EXT_HI);
    strb.rtrExtBit = act && isExt && (idx == POS_RTR_EXT);
    strb.dlcBit    = act && (idx > POS_IDE) && (idx >= dlcLo) && (idx <= dlcEnd);
    strb.dataBit   = act && (idx > dlcEnd) && (idx <= lastData);
    strb.dataOff   = dataOffWide[OFF_W-1:0];
    strb.crcBit    = act && (idx > lastData) && (idx <= lastData + OFS_CRC_HI);
    strb.ackBit    = act && (idx == lastData + OFS_ACK);
    strb.mustRec   = act && ((idx == lastData + OFS_CRC_DEL) ||
                             (idx == lastData + OFS_ACK_DEL) ||
                             ((idx >= lastData + OFS_EOF_LO) &&
                              (idx <= lastData + OFS_EOF_HI)));
    strb.done      = act && (idx == lastData + OFS_EOF_HI);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      state <= ST_IDLE;
    else if (sofHit)
      state <= ST_FIELDS;
    else if (strb.done)
      state <= ST_IDLE;
  end

  // R10: once the tail completes, no field strobe fires until a new start bit
  a_r10_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> !(strb.crcBit || strb.ackBit || strb.mustRec || strb.done));
endmodule

// File: rtl/canFieldDp.sv
module canFieldDp
  import canParsePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitVal,
  input  fieldStrb_t        strb,
  output logic [ID_W-1:0]   frameId,
  output logic              isExt,
  output logic              isRemote,
  output logic [DLC_W-1:0]  dlc,
  output logic [DATA_W-1:0] dataOut,
  output logic [CRC_W-1:0]  crcOut,
  output logic              ackOk,
  output logic              sofWarn,
  output logic              formErr,
  output logic              frameDone
);
  logic [BASE_ID_W-1:0] baseId;
  logic [EXT_ID_W-1:0]  extId;
  logic                 rtrStd;
  logic                 rtrExt;
  logic [OFF_W-1:0]     dataPos;

  // byte number from the upper offset bits, bit within byte reversed (MSB first)
  assign dataPos = {strb.dataOff[OFF_W-1:3], ~strb.dataOff[2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseId    <= '0;
      extId     <= '0;
      rtrStd    <= 1'b0;
      rtrExt    <= 1'b0;
      isExt     <= 1'b0;
      dlc       <= '0;
      dataOut   <= '0;
      crcOut    <= '0;
      ackOk     <= 1'b0;
      sofWarn   <= 1'b0;
      formErr   <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= strb.done;
      if (strb.sof) begin
        baseId  <= '0;
        extId   <= '0;
        rtrStd  <= 1'b0;
        rtrExt  <= 1'b0;
        isExt   <= 1'b0;
        dlc     <= '0;
        dataOut <= '0;
        crcOut  <= '0;
        ackOk   <= 1'b0;
        sofWarn <= bitVal;
        formErr <= 1'b0;
      end else begin
        if (strb.baseBit)   baseId <= {baseId[BASE_ID_W-2:0], bitVal};
        if (strb.bit12)     rtrStd <= bitVal;
        if (strb.ideBit)    isExt  <= bitVal;
        if (strb.extBit)    extId  <= {extId[EXT_ID_W-2:0], bitVal};
        if (strb.rtrExtBit) rtrExt <= bitVal;
        if (strb.dlcBit)    dlc    <= {dlc[DLC_W-2:0], bitVal};
        if (strb.dataBit)   dataOut[dataPos] <= bitVal;
        if (strb.crcBit)    crcOut <= {crcOut[CRC_W-2:0], bitVal};
        if (strb.ackBit)    ackOk  <= ~bitVal;
        if (strb.mustRec && !bitVal) formErr <= 1'b1;
      end
    end
  end

  assign isRemote = isExt ? rtrExt : rtrStd;
  assign frameId  = isExt ? {baseId, extId} : {{EXT_ID_W{1'b0}}, baseId};

  // R10: completion is a single-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
  // R9: the error flag only clears on a new start bit
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (formErr && !strb.sof) |=> formErr);
endmodule

// File: rtl/canFrameParser.sv
module canFrameParser
  import canParsePkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              bitVal,
  input  logic [IDX_W-1:0]  bitIdx,
  output logic [ID_W-1:0]   frameId,
  output logic              isExt,
  output logic              isRemote,
  output logic [DLC_W-1:0]  dlc,
  output logic [DATA_W-1:0] dataOut,
  output logic [CRC_W-1:0]  crcOut,
  output logic              ackOk,
  output logic              sofWarn,
  output logic              formErr,
  output logic              frameDone
);
  fieldStrb_t strb;

  canFieldCtrl #(.IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIdx(bitIdx),
    .isExt(isExt), .isRemote(isRemote), .dlcRaw(dlc), .strb(strb)
  );

  canFieldDp uDp (
    .clk(clk), .rstN(rstN), .bitVal(bitVal), .strb(strb),
    .frameId(frameId), .isExt(isExt), .isRemote(isRemote), .dlc(dlc),
    .dataOut(dataOut), .crcOut(crcOut), .ackOk(ackOk), .sofWarn(sofWarn),
    .formErr(formErr), .frameDone(frameDone)
  );

  // R1: a start bit clears the decoded fields
  a_r1_clear: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && bitIdx == '0) |=> (dataOut == '0 && crcOut == '0 &&
                                    !formErr && !frameDone && !isExt));
  // R9: the error flag rises only on an accepted dominant bit
  a_r9_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(formErr) |-> $past(bitValid && !bitVal));
  // R2: a finished standard frame carries no upper identifier bits
  a_r2_std_id: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !isExt) |-> (frameId[ID_W-1:BASE_ID_W] == '0));
  // R11: decoded fields hold after completion while no start bit arrives
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !(bitValid && bitIdx == '0)) |=>
      ($stable(frameId) && $stable(dataOut) && $stable(crcOut) && $stable(dlc)));
endmodule

// File: tb/tb_canFrameParser.sv
module tb_canFrameParser;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitVal = 1'b1;
  logic [6:0]  bitIdx = '0;
  logic [28:0] frameId;
  logic        isExt, isRemote, ackOk, sofWarn, formErr, frameDone;
  logic [3:0]  dlc;
  logic [63:0] dataOut;
  logic [14:0] crcOut;

  int checks = 0;
  int failures = 0;
  logic fb [0:127];
  int   fLen;

  always #4 clk = ~clk;

  canFrameParser dut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitVal(bitVal), .bitIdx(bitIdx),
    .frameId(frameId), .isExt(isExt), .isRemote(isRemote), .dlc(dlc),
    .dataOut(dataOut), .crcOut(crcOut), .ackOk(ackOk), .sofWarn(sofWarn),
    .formErr(formErr), .frameDone(frameDone)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // badPos: 0 none, 1 CRC delimiter, 2 ACK delimiter, 3..9 EOF bit (badPos-3)
  function automatic void buildFrame(input logic sofBad, input logic ext,
      input logic [10:0] base, input logic [17:0] ext18, input logic rtr,
      input logic [3:0] dl, input logic [63:0] dat, input logic [14:0] crc,
      input logic ackBit, input int badPos, input logic [2:0] rsv);
    int p;
    int nb;
    p = 0;
    fb[p] = sofBad; p++;
    for (int i = 10; i >= 0; i--) begin fb[p] = base[i]; p++; end
    if (!ext) begin
      fb[p] = rtr; p++;
      fb[p] = 1'b0; p++;
      fb[p] = rsv[0]; p++;
    end else begin
      fb[p] = rsv[2]; p++;
      fb[p] = 1'b1; p++;
      for (int i = 17; i >= 0; i--) begin fb[p] = ext18[i]; p++; end
      fb[p] = rtr; p++;
      fb[p] = rsv[1]; p++;
      fb[p] = rsv[0]; p++;
    end
    for (int i = 3; i >= 0; i--) begin fb[p] = dl[i]; p++; end
    nb = rtr ? 0 : ((dl > 8) ? 8 : int'(dl));
    for (int k = 0; k < nb; k++)
      for (int i = 7; i >= 0; i--) begin fb[p] = dat[8*k+i]; p++; end
    for (int i = 14; i >= 0; i--) begin fb[p] = crc[i]; p++; end
    fb[p] = (badPos == 1) ? 1'b0 : 1'b1; p++;
    fb[p] = ackBit; p++;
    fb[p] = (badPos == 2) ? 1'b0 : 1'b1; p++;
    for (int e = 0; e < 7; e++) begin fb[p] = (badPos == 3 + e) ? 1'b0 : 1'b1; p++; end
    fLen = p;
  endfunction

  function automatic logic [63:0] expData(input logic rtr, input logic [3:0] dl,
      input logic [63:0] dat);
    logic [63:0] r;
    int nb;
    r = '0;
    nb = rtr ? 0 : ((dl > 8) ? 8 : int'(dl));
    for (int k = 0; k < nb; k++) r[8*k +: 8] = dat[8*k +: 8];
    return r;
  endfunction

  task automatic runFrame(input string tag, input logic sofBad, input logic ext,
      input logic [10:0] base, input logic [17:0] ext18, input logic rtr,
      input logic [3:0] dl, input logic [63:0] dat, input logic [14:0] crc,
      input logic ackBit, input int badPos, input logic [2:0] rsv, input bit gaps);
    int early;
    logic [28:0] idExp;
    early = 0;
    buildFrame(sofBad, ext, base, ext18, rtr, dl, dat, crc, ackBit, badPos, rsv);
    idExp = ext ? {base, ext18} : {18'b0, base};
    for (int i = 0; i < fLen; i++) begin
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
      @(negedge clk);
      bitValid = 1'b1; bitVal = fb[i]; bitIdx = 7'(i);
      @(negedge clk);
      bitValid = 1'b0;
      if (i == 0) chk({tag, " R1 cleared data"}, dataOut, 64'h0);
      if (i < fLen - 1 && frameDone) early++;
    end
    chk({tag, " R10 done pulse"}, {63'b0, frameDone}, 64'h1);
    chk({tag, " R10 no early done"}, 64'(early), 64'h0);
    chk({tag, " R2/R3 id"}, {35'b0, frameId}, {35'b0, idExp});
    chk({tag, " R3 isExt"}, {63'b0, isExt}, {63'b0, ext});
    chk({tag, " R4 isRemote"}, {63'b0, isRemote}, {63'b0, rtr});
    chk({tag, " R5 dlc"}, {60'b0, dlc}, {60'b0, dl});
    chk({tag, " R5/R6 data"}, dataOut, expData(rtr, dl, dat));
    chk({tag, " R7 crc"}, {49'b0, crcOut}, {49'b0, crc});
    chk({tag, " R8 ack"}, {63'b0, ackOk}, {63'b0, ~ackBit});
    chk({tag, " R1 sofWarn"}, {63'b0, sofWarn}, {63'b0, sofBad});
    chk({tag, " R9 formErr"}, {63'b0, formErr}, {63'b0, (badPos != 0)});
    @(negedge clk);
    chk({tag, " R10 pulse ends"}, {63'b0, frameDone}, 64'h0);
  endtask

  task automatic strayCheck();
    logic [63:0] d0;
    logic [28:0] i0;
    logic [14:0] c0;
    d0 = dataOut; i0 = frameId; c0 = crcOut;
    @(negedge clk); bitValid = 1'b1; bitVal = 1'b0; bitIdx = 7'd5;
    @(negedge clk); bitVal = 1'b1; bitIdx = 7'd40;
    @(negedge clk); bitVal = 1'b0; bitIdx = 7'd120;
    @(negedge clk); bitValid = 1'b0;
    @(negedge clk);
    chk("R11 data held", dataOut, d0);
    chk("R11 id held", {35'b0, frameId}, {35'b0, i0});
    chk("R11 crc held", {49'b0, crcOut}, {49'b0, c0});
    chk("R11 no done", {63'b0, frameDone}, 64'h0);
  endtask

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset done", {63'b0, frameDone}, 64'h0);
    chk("R1 reset data", dataOut, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    runFrame("std2", 0, 0, 11'h5A3, 18'h0, 0, 4'd2, 64'h0000_0000_0000_C35A, 15'h1234, 0, 0, 3'b000, 0);
    strayCheck();
    runFrame("ext8", 0, 1, 11'h7F0, 18'h2_ABCD, 0, 4'd8, 64'h0123_4567_89AB_CDEF, 15'h7FFF, 0, 0, 3'b101, 1);
    runFrame("R4 stdRemote", 0, 0, 11'h123, 18'h0, 1, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 15'h5555, 0, 0, 3'b000, 0);
    runFrame("R4 extRemote", 0, 1, 11'h001, 18'h3_FFFF, 1, 4'd5, 64'hAAAA_AAAA_AAAA_AAAA, 15'h0001, 0, 0, 3'b011, 0);
    runFrame("R4 extSrrDominant", 0, 1, 11'h0F0, 18'h1_0001, 0, 4'd1, 64'h0000_0000_0000_0081, 15'h2AAA, 0, 0, 3'b000, 0);
    runFrame("R6 dlc12", 0, 0, 11'h400, 18'h0, 0, 4'd12, 64'hDEAD_BEEF_CAFE_F00D, 15'h4321, 0, 0, 3'b000, 1);
    runFrame("R6 dlc15ext", 0, 1, 11'h3FF, 18'h0_0001, 0, 4'd15, 64'h1122_3344_5566_7788, 15'h0F0F, 0, 0, 3'b111, 0);
    runFrame("R5 dlc0", 0, 0, 11'h2AA, 18'h0, 0, 4'd0, 64'hFFFF, 15'h6000, 0, 0, 3'b000, 0);
    runFrame("R1 sofBad", 1, 0, 11'h055, 18'h0, 0, 4'd1, 64'h7E, 15'h0003, 0, 0, 3'b000, 0);
    runFrame("R8 nack", 0, 0, 11'h100, 18'h0, 0, 4'd1, 64'h01, 15'h1111, 1, 0, 3'b000, 0);
    runFrame("R9 crcDelim", 0, 0, 11'h321, 18'h0, 0, 4'd2, 64'hBEEF, 15'h2222, 0, 1, 3'b000, 0);
    runFrame("R9 ackDelim", 0, 1, 11'h321, 18'h1_2345, 0, 4'd1, 64'h5A, 15'h3333, 0, 2, 3'b000, 0);
    runFrame("R9 eofLast", 0, 0, 11'h6E5, 18'h0, 0, 4'd3, 64'h00AB_CDEF, 15'h4444, 0, 9, 3'b000, 1);
    runFrame("R9 eofFirst", 0, 1, 11'h6E5, 18'h2_0000, 1, 4'd0, 64'h0, 15'h4444, 0, 3, 3'b000, 0);
    runFrame("R12 rsvLow", 0, 1, 11'h19C, 18'h0_F00F, 0, 4'd2, 64'h3C5A, 15'h0ACE, 0, 0, 3'b000, 0);
    runFrame("R12 rsvHigh", 0, 1, 11'h19C, 18'h0_F00F, 0, 4'd2, 64'h3C5A, 15'h0ACE, 0, 0, 3'b111, 0);
    runFrame("R12 stdRsvHigh", 0, 0, 11'h19C, 18'h0, 0, 4'd2, 64'h3C5A, 15'h0ACE, 0, 0, 3'b001, 0);
    strayCheck();
    for (int n = 0; n < 40; n++) begin
      logic [63:0] rd;
      rd = {$urandom(), $urandom()};
      runFrame("rand", 1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)),
               11'($urandom()), 18'($urandom()), 1'($urandom_range(0, 4) == 0),
               4'($urandom()), rd, 15'($urandom()), 1'($urandom_range(0, 3) == 0),
               ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 9)) : 0,
               3'($urandom()), 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule